// File: doc/BRIEF.md
# External Interrupt Controller with Vectoring

This block collects two external interrupt pins for a small 8-bit processor core and presents one vectored request to it. Each pin is brought into the clock domain through a two-stage synchronizer. A per-pin sense field then picks how the pin triggers: while it is held low, on a falling edge, or on a rising edge. In the two edge modes a detected edge latches a pending flag. In low-level mode the pin drives the request directly while it stays low, and no flag is latched.

A request reaches the core only when its mask bit and the global enable bit are both set. When the core acknowledges a pending request, the block returns a fixed program address for the winning source. In the same cycle it clears that source's pending flag and the global enable bit, so software has to set the enable again before the next interrupt can be taken. Software reads and writes the mask, flag, sense and control registers over a simple single-cycle register bus. A flag can also be cleared by writing a one to it.

Top module: `extint_ctrl`

## Requirements
- R1: The mask register is at address 0. Bit 7 enables request 1 and bit 6 enables request 0; both are read/write. Bits 5 to 0 ignore writes and always read as zero.
- R2: The sense register is at address 2. Bits [1:0] set the mode of pin 0 and bits [3:2] set the mode of pin 1: 00 is low level, 10 is falling edge and 11 is rising edge. In an edge mode, a matching edge on the synchronized pin sets that pin's pending flag. The flags are read at address 1: bit 6 for request 0 and bit 7 for request 1. An edge of the opposite direction sets nothing.
- R3: `irq_o` is high only when a source has its mask bit set, the global enable (address 3, bit 7, also shown on `gie_o`) is set, and that source is active. A source is active when its flag is set in an edge mode, or when its pin is low in level mode.
- R4: When `ack_i` is high while `irq_o` is high, the global enable is clear from the next cycle on.
- R5: The acknowledge clears the pending flag of the source whose vector was returned, and only that flag.
- R6: `vec_o` is 0x001 for request 0 and 0x002 for request 1.
- R7: Writing to address 1 clears each flag whose data bit is one. A flag whose data bit is zero is left unchanged.
- R8: When both requests are active, request 0 is presented first.
- R9: In level mode no flag is latched. The request reasserts each time the global enable is set while the pin is still low, and it stops once the pin returns high.
- R10: If an edge sets a flag in the same cycle that a clear targets that flag, the flag ends up set.
- R11: Sense code 01 triggers on nothing.
- R12: After reset all registers read zero and `irq_o` and `gie_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mask, 1 flags, 2 sense, 3 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ext_pin | input | 2 | External interrupt pins (bit i is request i) |
| irq_o | output | 1 | Interrupt request to the core |
| ack_i | input | 1 | Core accepts the presented interrupt |
| vec_o | output | 12 | Vector address of the presented request |
| gie_o | output | 1 | Global interrupt enable bit |

## Verification
The hazardous overlap is an edge that sets a pending flag landing in the same clock as a write-one clear of that same flag. The bench first latches a flag. It then drives a fresh falling edge, counts the synchronizer stages, and places the clearing write exactly on the clock where the detected edge is registered. The flag is judged by reading it back afterwards, where it must still be set. A second overlap, two flags pending at once, is judged by the scoreboard, which expects vector 0x001 and then 0x002 and sees request 1's flag survive the first acknowledge.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int NSRC = 2;
    localparam int DW   = 8;
    localparam int VW   = 12;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_OFF  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        A_MASK  = 2'd0,
        A_FLAG  = 2'd1,
        A_SENSE = 2'd2,
        A_CTRL  = 2'd3
    } addr_e;

    typedef struct packed {
        logic level_req;
        logic edge_hit;
    } det_s;
endpackage

// File: rtl/extint_sense.sv
module extint_sense
    import extint_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin,
    input  sense_e mode,
    output det_s   det
);
    // stage 0 and 1 synchronize, stage 2 holds the previous sample
    logic [2:0] sh_q;
    logic       cur, prev;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= 3'b111;
        else     sh_q <= {sh_q[1:0], pin};
    end

    assign cur  = sh_q[1];
    assign prev = sh_q[2];

    always_comb begin
        det.level_req = (mode == SNS_LOW) && !cur;
        unique case (mode)
            SNS_FALL: det.edge_hit = prev && !cur;
            SNS_RISE: det.edge_hit = !prev && cur;
            default:  det.edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/extint_arb.sv
module extint_arb #(
    parameter int N  = 2,
    parameter int VW = 12
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] sel,
    output logic [VW-1:0] vec
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    // scanning downward leaves the lowest index as the winner
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                sel = IW'(i);
            end
        end
        vec = any ? (VW'(sel) + VW'(1)) : '0;
    end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NSRC  = extint_pkg::NSRC,
    parameter int DW    = extint_pkg::DW,
    parameter int VEC_W = extint_pkg::VW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [NSRC-1:0]  ext_pin,
    output logic             irq_o,
    input  logic             ack_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             gie_o
);
    localparam int SRC_LSB = DW - NSRC;
    localparam int SW      = 2 * NSRC;
    localparam int IW      = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] mask_q, flag_q, flag_d;
    logic [SW-1:0]   sense_q;
    logic            gie_q;
    logic [NSRC-1:0] req_w, edge_w;
    logic [IW-1:0]   sel_w;
    logic            take;
    logic            wr_mask, wr_flag, wr_sense, wr_ctrl;
    logic            unused_bits;
    det_s            det_w  [NSRC];
    sense_e          mode_w [NSRC];

    assign wr_mask  = reg_wr && (addr_e'(reg_addr) == A_MASK);
    assign wr_flag  = reg_wr && (addr_e'(reg_addr) == A_FLAG);
    assign wr_sense = reg_wr && (addr_e'(reg_addr) == A_SENSE);
    assign wr_ctrl  = reg_wr && (addr_e'(reg_addr) == A_CTRL);
    assign unused_bits = ^reg_wdata[SRC_LSB-1:SW];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign mode_w[i] = sense_e'(sense_q[2*i +: 2]);
        extint_sense u_sns (
            .clk  (clk),
            .rst  (rst),
            .pin  (ext_pin[i]),
            .mode (mode_w[i]),
            .det  (det_w[i])
        );
        assign edge_w[i] = det_w[i].edge_hit;
        assign req_w[i]  = mask_q[i] && gie_q &&
                           ((mode_w[i] == SNS_LOW) ? det_w[i].level_req : flag_q[i]);
    end

    extint_arb #(.N(NSRC), .VW(VEC_W)) u_arb (
        .req (req_w),
        .any (irq_o),
        .sel (sel_w),
        .vec (vec_o)
    );

    assign take  = ack_i && irq_o;
    assign gie_o = gie_q;

    // clears first, then a detected edge overrides them
    always_comb begin
        flag_d = flag_q;
        for (int i = 0; i < NSRC; i++) begin
            if (wr_flag && reg_wdata[SRC_LSB+i]) flag_d[i] = 1'b0;
            if (take && (sel_w == IW'(i)))       flag_d[i] = 1'b0;
            if (edge_w[i])                       flag_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            flag_q  <= '0;
            sense_q <= '0;
            gie_q   <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (wr_mask)  mask_q  <= reg_wdata[DW-1:SRC_LSB];
            if (wr_sense) sense_q <= reg_wdata[SW-1:0];
            if (take)         gie_q <= 1'b0;
            else if (wr_ctrl) gie_q <= reg_wdata[DW-1];
        end
    end

    always_comb begin
        unique case (addr_e'(reg_addr))
            A_MASK:  reg_rdata = {mask_q, {SRC_LSB{1'b0}}};
            A_FLAG:  reg_rdata = {flag_q, {SRC_LSB{1'b0}}};
            A_SENSE: reg_rdata = {{(DW-SW){1'b0}}, sense_q};
            default: reg_rdata = {gie_q, {(DW-1){1'b0}}};
        endcase
    end
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        irq_o,
    input logic        ack_i,
    input logic        gie_o,
    input logic [11:0] vec_o,
    input logic [1:0]  reg_addr,
    input logic [5:0]  rsv_bits,
    input logic        req0
);
    assert_irq_gated_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> gie_o);

    assert_ack_drops_gie_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> !gie_o);

    assert_vector_value_R6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (vec_o == 12'h001 || vec_o == 12'h002));

    assert_low_first_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_o && req0) |-> (vec_o == 12'h001));

    assert_mask_rsv_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> (rsv_bits == 6'd0));
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_o    (irq_o),
    .ack_i    (ack_i),
    .gie_o    (gie_o),
    .vec_o    (vec_o),
    .reg_addr (reg_addr),
    .rsv_bits (reg_rdata[5:0]),
    .req0     (req_w[0])
);

// File: tb/extint_ctrl_tb.sv
module extint_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [1:0]  ext_pin = 2'b11;
    logic        irq_o;
    logic        ack_i = 1'b0;
    logic [11:0] vec_o;
    logic        gie_o;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned exp_q [$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extint_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .irq_o(irq_o), .ack_i(ack_i), .vec_o(vec_o), .gie_o(gie_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // all driver tasks are entered at a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_vec(input int unsigned v);
        exp_q.push_back(v);
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while ((exp_q.size() != 0 || ack_i) && t < 60) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        @(negedge clk);
    endtask

    // monitor: compare each presented vector with the scoreboard and accept it
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && irq_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected request", vec_o, 0);
                end else begin
                    int unsigned e;
                    e = exp_q.pop_front();
                    check(vec_o == e[11:0], "R6/R8 vector", vec_o, e);
                end
                ack_i = 1'b1;
                @(negedge clk);
                ack_i = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        rd_chk(2'd0, 8'h00, "R12 mask reset");
        rd_chk(2'd1, 8'h00, "R12 flag reset");
        rd_chk(2'd2, 8'h00, "R12 sense reset");
        rd_chk(2'd3, 8'h00, "R12 ctrl reset");
        check(irq_o == 1'b0 && gie_o == 1'b0, "R12 irq/gie low", {irq_o, gie_o}, 0);

        // R1 reserved mask bits
        wr(2'd0, 8'hFF);
        rd_chk(2'd0, 8'hC0, "R1 mask reserved bits");
        wr(2'd0, 8'h00);
        rd_chk(2'd0, 8'h00, "R1 mask cleared");

        // R9 level mode (sense 00 after reset) on pin 0
        wr(2'd0, 8'h40);
        ext_pin[0] = 1'b0;
        idle(4);
        check(irq_o == 1'b0, "R3 level gated by gie", irq_o, 0);
        expect_vec(1);
        wr(2'd3, 8'h80);
        drain("R9 level request taken");
        rd_chk(2'd3, 8'h00, "R4 gie cleared on ack");
        rd_chk(2'd1, 8'h00, "R9 no flag in level mode");
        expect_vec(1);
        wr(2'd3, 8'h80);
        drain("R9 level request reasserts");
        ext_pin[0] = 1'b1;
        idle(4);
        wr(2'd3, 8'h80);
        idle(4);
        check(irq_o == 1'b0, "R9 released pin no request", irq_o, 0);
        wr(2'd3, 8'h00);

        // R2 edge modes: pin0 falling, pin1 rising
        wr(2'd2, 8'h0E);
        rd_chk(2'd2, 8'h0E, "R2 sense readback");
        wr(2'd0, 8'hC0);
        ext_pin[0] = 1'b0;
        idle(4);
        rd_chk(2'd1, 8'h40, "R2 falling edge sets flag0");
        check(irq_o == 1'b0, "R3 flag gated by gie", irq_o, 0);
        ext_pin[0] = 1'b1;
        idle(4);
        rd_chk(2'd1, 8'h40, "R2 rising ignored in falling mode");

        // R4 R5 R6 take request 0
        expect_vec(1);
        wr(2'd3, 8'h80);
        drain("R6 request 0 taken");
        rd_chk(2'd1, 8'h00, "R5 flag0 cleared by ack");
        rd_chk(2'd3, 8'h00, "R4 gie cleared");

        // pin1 rising mode
        ext_pin[1] = 1'b0;
        idle(4);
        rd_chk(2'd1, 8'h00, "R2 falling ignored in rising mode");
        ext_pin[1] = 1'b1;
        idle(4);
        rd_chk(2'd1, 8'h80, "R2 rising edge sets flag1");
        expect_vec(2);
        wr(2'd3, 8'h80);
        drain("R6 request 1 taken");
        rd_chk(2'd1, 8'h00, "R5 flag1 cleared by ack");

        // R7 write-one-to-clear
        ext_pin[0] = 1'b0;
        idle(4);
        wr(2'd1, 8'h00);
        rd_chk(2'd1, 8'h40, "R7 zero write keeps flag");
        wr(2'd1, 8'h40);
        rd_chk(2'd1, 8'h00, "R7 one write clears flag");
        ext_pin[0] = 1'b1;
        idle(4);

        // R8 priority with both pending
        ext_pin[1] = 1'b0;
        idle(4);
        ext_pin[0] = 1'b0;
        ext_pin[1] = 1'b1;
        idle(4);
        rd_chk(2'd1, 8'hC0, "R8 both flags pending");
        expect_vec(1);
        wr(2'd3, 8'h80);
        drain("R8 request 0 first");
        rd_chk(2'd1, 8'h80, "R5 only returned flag cleared");
        expect_vec(2);
        wr(2'd3, 8'h80);
        drain("R8 request 1 second");
        rd_chk(2'd1, 8'h00, "R5 flag1 cleared after second ack");
        ext_pin[0] = 1'b1;
        idle(4);

        // R3 mask gating
        wr(2'd0, 8'h80);
        ext_pin[0] = 1'b0;
        idle(4);
        rd_chk(2'd1, 8'h40, "R3 masked flag still latched");
        wr(2'd3, 8'h80);
        idle(4);
        check(irq_o == 1'b0, "R3 masked source no request", irq_o, 0);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h40);
        wr(2'd0, 8'hC0);
        ext_pin[0] = 1'b1;
        idle(4);

        // R11 reserved sense code on pin 0
        wr(2'd2, 8'h0D);
        ext_pin[0] = 1'b0;
        idle(4);
        ext_pin[0] = 1'b1;
        idle(4);
        rd_chk(2'd1, 8'h00, "R11 sense 01 never triggers");
        wr(2'd2, 8'h0E);
        idle(2);

        // R10 edge set and write-one clear in the same cycle
        ext_pin[0] = 1'b0;
        idle(4);
        rd_chk(2'd1, 8'h40, "R10 flag pre-set");
        ext_pin[0] = 1'b1;
        idle(4);
        ext_pin[0] = 1'b0;
        idle(2);
        wr(2'd1, 8'h40);
        rd_chk(2'd1, 8'h40, "R10 edge wins over clear");
        wr(2'd1, 8'h40);
        rd_chk(2'd1, 8'h00, "R10 later clear works");

        idle(4);
        check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);
        finish_run();
    end
endmodule